// File: doc/BRIEF.md
# SIMD Divergence Mask Stack

This block tracks which lanes of a SIMD group are enabled while the group runs one shared instruction stream through IF-THEN-ELSE code. Three branch markers drive it. A split marker opens a conditional: it saves the current mask on a stack and narrows the mask to the active lanes whose predicate is true. A flip marker starts the ELSE body. It enables the lanes that were active before the split but did not take THEN. A join marker closes the conditional and restores the saved mask. A lane whose mask bit is clear stays idle for that cycle. All enabled lanes always run the same operation.

When the lanes agree, issuing a body with no lanes enabled wastes cycles. In that case the block requests a redirect to the target that the marker instruction carries. A split whose THEN mask comes out empty redirects past the THEN body. A flip whose ELSE mask comes out empty redirects past the ELSE body. The markers still update the stack on a uniform branch, so every split is still balanced by a join. The stack depth sets the nesting limit. Sticky flags record a split on a full stack and a flip or join on an empty one.

All outputs are registered. Each output reflects a marker in the clock cycle that follows it.

Top module: `simd_mask_stack`

## Requirements
- R1: While reset is high and in the first cycle after it, the mask is all ones, the stack is empty, both error flags are low and no redirect is requested.
- R2: A split marker (`br_split_i`) on a stack that is not full pushes the current mask. The next mask is the current mask AND the predicate. When several markers are high in one cycle, split wins over flip, and flip wins over join.
- R3: A flip marker on a non-empty stack sets the mask to the saved top entry AND NOT the current mask. Lanes that were inactive before the split stay disabled. The stack is unchanged.
- R4: A join marker on a non-empty stack restores the top entry as the mask and removes it.
- R5: A split redirects when no active lane has a true predicate, including when no lane is active. In the next cycle `redirect_o` is 1 and `redirect_tgt_o` equals `br_target_i`. Predicate bits of inactive lanes have no effect.
- R6: A flip redirects, with `redirect_tgt_o` equal to `br_target_i`, when the ELSE mask it produces is all zeros.
- R7: A split on which every active lane has a true predicate, or a split with a mixed predicate, requests no redirect. A join never requests one.
- R8: Conditionals nest up to DEPTH levels, and joins restore masks in last-in, first-out order.
- R9: A split when DEPTH entries are stored leaves the mask and the stack unchanged, requests no redirect, and sets `overflow_o`. The flag stays high until reset.
- R10: A flip or a join on an empty stack leaves the mask unchanged, requests no redirect, and sets `underflow_o`. The flag stays high until reset.
- R11: In a cycle with no marker, the mask and the stack hold, and `redirect_o` is 0 in the next cycle. `redirect_tgt_o` is 0 whenever `redirect_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_split_i | input | 1 | Split marker: save the mask and enable the THEN lanes |
| br_flip_i | input | 1 | Flip marker: switch to the ELSE lanes |
| br_join_i | input | 1 | Join marker: restore the saved mask |
| pred_i | input | LANES | Per-lane branch predicate (1 means THEN) |
| br_target_i | input | ADDR_W | Target address carried by the marker instruction |
| mask_o | output | LANES | Current active-lane mask |
| redirect_o | output | 1 | Uniform branch: fetch should jump |
| redirect_tgt_o | output | ADDR_W | Jump target, 0 when no redirect |
| overflow_o | output | 1 | Sticky flag: split on a full stack |
| underflow_o | output | 1 | Sticky flag: flip or join on an empty stack |

## Verification
A stack entry that is lost or corrupted does not show up when it is written. It shows up at the next flip or join that reads it. A wrong mask then appears on `mask_o` in the cycle after that marker, and it can surface as a missing or spurious redirect on a flip. A wrong depth count first appears as a flag that rises on the wrong marker, or as a restore of the wrong level. Because of this, the stimulus nests conditionals, walks the stack to both ends, and compares every output against a queue-based model on every clock, so the error is reported at the first marker that exposes it.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;

    typedef enum logic [1:0] {
        BR_NONE  = 2'd0,
        BR_SPLIT = 2'd1,
        BR_FLIP  = 2'd2,
        BR_JOIN  = 2'd3
    } br_op_e;

    // Split takes priority over flip, and flip over join.
    function automatic br_op_e decode_marker(input logic split, input logic flip,
                                             input logic join_m);
        if (split)       return BR_SPLIT;
        else if (flip)   return BR_FLIP;
        else if (join_m) return BR_JOIN;
        else             return BR_NONE;
    endfunction

endpackage

// File: rtl/mask_lifo.sv
module mask_lifo #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] data_i,
    output logic [LANES-1:0] top_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] top_idx;
    logic [LANES-1:0] mem_q [DEPTH];

    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign empty_o = (count_q == '0);
    assign top_idx = count_q - CNT_W'(1);
    assign top_o   = empty_o ? '1 : mem_q[top_idx[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (push_i && !full_o) begin
            count_q <= count_q + CNT_W'(1);
        end else if (pop_i && !empty_o) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_i && !full_o && (count_q == CNT_W'(e))) begin
                mem_q[e] <= data_i;
            end
        end
    end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import simd_mask_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  br_op_e            op_i,
    input  logic [LANES-1:0]  cur_mask_i,
    input  logic [LANES-1:0]  pred_i,
    input  logic [LANES-1:0]  saved_i,
    input  logic              full_i,
    input  logic              empty_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [LANES-1:0]  nxt_mask_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_tgt_o,
    output logic              stk_push_o,
    output logic              stk_pop_o,
    output logic              ovf_evt_o,
    output logic              unf_evt_o
);
    logic [LANES-1:0] then_mask;
    logic [LANES-1:0] else_mask;

    assign then_mask = cur_mask_i & pred_i;
    assign else_mask = saved_i & ~cur_mask_i;

    always_comb begin
        nxt_mask_o = cur_mask_i;
        redirect_o = 1'b0;
        stk_push_o = 1'b0;
        stk_pop_o  = 1'b0;
        ovf_evt_o  = 1'b0;
        unf_evt_o  = 1'b0;
        unique case (op_i)
            BR_SPLIT: begin
                if (full_i) begin
                    ovf_evt_o = 1'b1;
                end else begin
                    stk_push_o = 1'b1;
                    nxt_mask_o = then_mask;
                    redirect_o = (then_mask == '0);
                end
            end
            BR_FLIP: begin
                if (empty_i) begin
                    unf_evt_o = 1'b1;
                end else begin
                    nxt_mask_o = else_mask;
                    redirect_o = (else_mask == '0);
                end
            end
            BR_JOIN: begin
                if (empty_i) begin
                    unf_evt_o = 1'b1;
                end else begin
                    stk_pop_o  = 1'b1;
                    nxt_mask_o = saved_i;
                end
            end
            default: ;
        endcase
        redirect_tgt_o = redirect_o ? target_i : '0;
    end

endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack
    import simd_mask_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_split_i,
    input  logic              br_flip_i,
    input  logic              br_join_i,
    input  logic [LANES-1:0]  pred_i,
    input  logic [ADDR_W-1:0] br_target_i,
    output logic [LANES-1:0]  mask_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_tgt_o,
    output logic              overflow_o,
    output logic              underflow_o
);
    br_op_e            op;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  saved;
    logic              stk_full;
    logic              stk_empty;
    logic [LANES-1:0]  nxt_mask;
    logic              nxt_redirect;
    logic [ADDR_W-1:0] nxt_tgt;
    logic              stk_push;
    logic              stk_pop;
    logic              ovf_evt;
    logic              unf_evt;
    logic              redirect_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              ovf_q;
    logic              unf_q;

    assign op = decode_marker(br_split_i, br_flip_i, br_join_i);

    mask_lifo #(.LANES(LANES), .DEPTH(DEPTH)) u_lifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (stk_push),
        .pop_i   (stk_pop),
        .data_i  (mask_q),
        .top_o   (saved),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    branch_eval #(.LANES(LANES), .ADDR_W(ADDR_W)) u_eval (
        .op_i           (op),
        .cur_mask_i     (mask_q),
        .pred_i         (pred_i),
        .saved_i        (saved),
        .full_i         (stk_full),
        .empty_i        (stk_empty),
        .target_i       (br_target_i),
        .nxt_mask_o     (nxt_mask),
        .redirect_o     (nxt_redirect),
        .redirect_tgt_o (nxt_tgt),
        .stk_push_o     (stk_push),
        .stk_pop_o      (stk_pop),
        .ovf_evt_o      (ovf_evt),
        .unf_evt_o      (unf_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '1;
            redirect_q <= 1'b0;
            tgt_q      <= '0;
            ovf_q      <= 1'b0;
            unf_q      <= 1'b0;
        end else begin
            mask_q     <= nxt_mask;
            redirect_q <= nxt_redirect;
            tgt_q      <= nxt_tgt;
            ovf_q      <= ovf_q | ovf_evt;
            unf_q      <= unf_q | unf_evt;
        end
    end

    assign mask_o         = mask_q;
    assign redirect_o     = redirect_q;
    assign redirect_tgt_o = tgt_q;
    assign overflow_o     = ovf_q;
    assign underflow_o    = unf_q;

endmodule

// File: rtl/simd_mask_stack_chk.sv
module simd_mask_stack_chk #(
    parameter int LANES  = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              br_split_i,
    input logic              br_flip_i,
    input logic              br_join_i,
    input logic [LANES-1:0]  pred_i,
    input logic [ADDR_W-1:0] br_target_i,
    input logic [LANES-1:0]  mask_o,
    input logic              redirect_o,
    input logic [ADDR_W-1:0] redirect_tgt_o,
    input logic              overflow_o,
    input logic              underflow_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] depth_q;
    logic             is_full;
    logic             is_empty;
    logic             do_flip;
    logic             do_join;
    logic             no_marker;

    assign is_full   = (depth_q == CNT_W'(DEPTH));
    assign is_empty  = (depth_q == '0);
    assign do_flip   = !br_split_i && br_flip_i;
    assign do_join   = !br_split_i && !br_flip_i && br_join_i;
    assign no_marker = !br_split_i && !br_flip_i && !br_join_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else if (br_split_i && !is_full) begin
            depth_q <= depth_q + CNT_W'(1);
        end else if (do_join && !is_empty) begin
            depth_q <= depth_q - CNT_W'(1);
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_o == '1 && !redirect_o && !overflow_o && !underflow_o)); // R1
    AST_SPLIT_NARROW: assert property (@(posedge clk) disable iff (rst)
        (br_split_i && !is_full) |=> mask_o == ($past(mask_o) & $past(pred_i))); // R2
    AST_FLIP_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (do_flip && !is_empty) |=> (mask_o & $past(mask_o)) == '0); // R3
    AST_SPLIT_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (br_split_i && !is_full && (mask_o & pred_i) == '0)
            |=> (redirect_o && redirect_tgt_o == $past(br_target_i))); // R5
    AST_JOIN_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        do_join |=> !redirect_o); // R7
    AST_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (br_split_i && is_full) |=> (overflow_o && $stable(mask_o) && !redirect_o)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o); // R9
    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        ((do_flip || do_join) && is_empty) |=> (underflow_o && $stable(mask_o))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        no_marker |=> ($stable(mask_o) && !redirect_o)); // R11
    AST_TGT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !redirect_o |-> redirect_tgt_o == '0); // R11

endmodule

bind simd_mask_stack simd_mask_stack_chk #(
    .LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_simd_mask_stack.sv
module tb_simd_mask_stack;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 32;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              br_split_i = 1'b0;
    logic              br_flip_i = 1'b0;
    logic              br_join_i = 1'b0;
    logic [LANES-1:0]  pred_i = '0;
    logic [ADDR_W-1:0] br_target_i = '0;
    logic [LANES-1:0]  mask_o;
    logic              redirect_o;
    logic [ADDR_W-1:0] redirect_tgt_o;
    logic              overflow_o;
    logic              underflow_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [LANES-1:0]  m_mask = '1;
    logic [LANES-1:0]  m_stk[$];
    bit                m_rd = 1'b0;
    logic [ADDR_W-1:0] m_tgt = '0;
    bit                m_ovf = 1'b0;
    bit                m_unf = 1'b0;

    simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic compare(input string req);
        vectors++;
        if (mask_o !== m_mask || redirect_o !== m_rd || redirect_tgt_o !== m_tgt ||
            overflow_o !== m_ovf || underflow_o !== m_unf) begin
            miscompares++;
            $display("FAIL %s: got mask=%h rd=%0b tgt=%h ovf=%0b unf=%0b, exp mask=%h rd=%0b tgt=%h ovf=%0b unf=%0b",
                     req, mask_o, redirect_o, redirect_tgt_o, overflow_o, underflow_o,
                     m_mask, m_rd, m_tgt, m_ovf, m_unf);
        end
    endtask

    // Behavioural reference: priority split > flip > join.
    task automatic model(input bit s, input bit f, input bit j,
                         input logic [LANES-1:0] p, input logic [ADDR_W-1:0] t);
        logic [LANES-1:0] nm;
        m_rd = 1'b0;
        if (s) begin
            if (m_stk.size() == DEPTH) m_ovf = 1'b1;
            else begin
                m_stk.push_back(m_mask);
                nm = m_mask & p;
                m_rd = (nm == '0);
                m_mask = nm;
            end
        end else if (f) begin
            if (m_stk.size() == 0) m_unf = 1'b1;
            else begin
                nm = m_stk[$] & ~m_mask;
                m_rd = (nm == '0);
                m_mask = nm;
            end
        end else if (j) begin
            if (m_stk.size() == 0) m_unf = 1'b1;
            else m_mask = m_stk.pop_back();
        end
        m_tgt = m_rd ? t : '0;
    endtask

    task automatic step(input bit s, input bit f, input bit j,
                        input logic [LANES-1:0] p, input logic [ADDR_W-1:0] t,
                        input string req);
        br_split_i = s; br_flip_i = f; br_join_i = j; pred_i = p; br_target_i = t;
        @(posedge clk);
        model(s, f, j, p, t);
        @(negedge clk);
        compare(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hang, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst = 1'b0;
        step(0, 0, 0, '0, '0, "R1 R11 first cycle after reset");

        // Divergent if-else
        step(1, 0, 0, 32'h0000_FFFF, 32'h100, "R2 split divergent");
        step(0, 1, 0, 32'h1234_5678, 32'h200, "R3 flip to else lanes");
        step(0, 0, 1, '0, 32'h300, "R4 join restores");

        // Uniform false: skip THEN
        step(1, 0, 0, 32'h0, 32'hA0, "R5 split all false redirects");
        step(0, 1, 0, '0, 32'hA4, "R3 R6 flip else nonempty no redirect");
        step(0, 0, 1, '0, 32'hA8, "R4 R7 join no redirect");

        // Uniform true: skip ELSE
        step(1, 0, 0, '1, 32'hB0, "R7 split all true no redirect");
        step(0, 1, 0, '0, 32'hB4, "R6 flip empty else redirects");
        step(0, 0, 1, '0, 32'hB8, "R4 join after uniform");

        // Nesting with inactive lanes
        step(1, 0, 0, 32'h0000_00FF, 32'hC0, "R2 R8 outer split");
        step(1, 0, 0, 32'hFF00_0000, 32'hC4, "R5 inactive lanes ignored");
        step(0, 1, 0, '0, 32'hC8, "R3 R8 inner flip");
        step(0, 0, 1, '0, 32'hCC, "R8 inner join");
        step(1, 0, 0, 32'hFF00_000F, 32'hD0, "R2 R8 inner split mixed");
        step(0, 1, 0, '0, 32'hD4, "R3 R8 inner flip keeps outer off");
        step(0, 0, 1, '0, 32'hD8, "R8 inner join");
        step(0, 1, 0, '0, 32'hDC, "R3 R8 outer flip");
        step(0, 0, 1, '0, 32'hE0, "R8 outer join");

        // Priority among markers
        step(1, 1, 1, 32'h0F0F_0F0F, 32'hE4, "R2 split wins priority");
        step(0, 1, 1, '0, 32'hE8, "R2 flip beats join");
        step(0, 0, 1, '0, 32'hEC, "R4 join");

        // Idle holds
        step(0, 0, 0, 32'hDEAD_BEEF, 32'hF0, "R11 idle");

        // Fill, overflow, drain, underflow
        for (int k = 0; k < DEPTH; k++)
            step(1, 0, 0, ~(32'h1 << k), 32'h1000 + k, "R8 fill");
        step(1, 0, 0, 32'h0, 32'h2000, "R9 overflow split ignored");
        step(0, 0, 0, '0, '0, "R9 overflow sticky");
        for (int k = 0; k < DEPTH; k++)
            step(0, 0, 1, '0, '0, "R8 drain LIFO");
        step(0, 0, 1, '0, '0, "R10 join on empty");
        step(0, 1, 0, '0, 32'h3000, "R10 flip on empty");
        step(0, 0, 0, '0, '0, "R10 underflow sticky");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule